// File: doc/BRIEF.md
# Byte-Counted SPI Configuration Register Access Slave

This block lets an external host read and write a bank of byte-wide configuration registers over a four-wire serial link. The host pulls the chip-select low to open a frame. It then clocks in a command byte and an address byte, followed by any number of data bytes. Data byte i acts on register address+i. Writes go out through a one-cycle write strobe on the register-file port. Reads are fetched through a combinational read port and shifted back on the serial output during the following byte.

The command byte has two parts. Its top two bits choose the operation: write, read, both at once, or nothing. Three further bits give an optional byte count. With a count of zero the access streams for as long as the chip-select stays low. With a non-zero count only that many data bytes take effect, and the rest of the frame is clocked through without changing anything.

All serial inputs are assumed to be synchronous to the block clock already; crossing clock domains is out of scope. Each SCK high phase and each SCK low phase must last at least four clock cycles. The register-file port has no back-pressure: the register file must accept a write in the cycle the strobe is high, and it must return read data for the presented address in the same cycle.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset, and in every cycle following a cycle with the chip-select high, `miso` is 0 and `reg_we` is 0.
- R2: Command bits [7:6] select the operation: 2'b10 write, 2'b01 read, 2'b11 read and write in the same frame, 2'b00 no operation. A no-operation frame writes nothing, and `miso` stays 0 for its whole length.
- R3: The address byte's low 7 bits give a start address A. Data byte i (counting from 0) acts on register A+i.
- R4: Command bits [5:3] hold a byte count N. When N is non-zero, only data bytes 0 to N-1 are written. Later bytes in the frame cause no write, and the registers they would have hit keep their values.
- R5: When N is zero, data bytes keep acting on successive registers until the chip-select rises.
- R6: In a read frame, data byte i returns register A+i on `miso`, MSB first, in SPI mode 0 (MOSI sampled on the SCK rising edge, MISO changed on the falling edge). When N is non-zero, bytes i >= N return 0x00. The command and address bytes always return 0x00.
- R7: When the chip-select rises mid-byte, the partial byte is discarded and nothing is written. The next frame starts again with a command byte.
- R8: The address advances from 0x7F to 0x00.
- R9: Any 8-bit value, including 0x1F and 0x00, is stored and read back unchanged.
- R10: Each committed data byte produces exactly one `reg_we` pulse, one clock cycle long, after that byte's last SCK rising edge.
- R11: In a read-and-write frame, data byte i returns the value register A+i held before the frame, while the byte on MOSI is written to A+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, idle low, synchronous to clk |
| csb | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when not reading |
| reg_we | output | 1 | Register-file write strobe, one cycle per byte |
| reg_addr | output | ADDR_W | Register address for both write and read |
| reg_wdata | output | 8 | Register-file write data |
| reg_rdata | input | 8 | Register-file read data for `reg_addr`, same cycle |

## Verification
The bench builds the block with its default 7-bit address. That makes the whole 128-entry bank small enough to compare against the reference image in every idle cycle, and it lets a frame that starts at 0x7E cross the wrap point in a few bytes. The 3-bit count field is exercised at 1, 2, 3 and its maximum of 7, each with more data bytes than the count. This shows the point at which writes stop and read bytes turn to zero.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/cfg_spi_rx.sv
module cfg_spi_rx
  import cfg_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csb,
  input  logic              mosi,
  output logic              sck_fall,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic [2:0]        bit_cnt
);
  logic              sck_d;
  logic              sck_rise;
  logic [BYTE_W-2:0] shreg;

  assign sck_rise  = sck & ~sck_d & ~csb;
  assign sck_fall  = ~sck & sck_d & ~csb;
  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign byte_val  = {shreg, mosi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sck_d <= sck;
      if (csb) begin
        shreg   <= '0;
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[BYTE_W-3:0], mosi};
        bit_cnt <= bit_cnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/cfg_spi_ctrl.sv
module cfg_spi_ctrl
  import cfg_spi_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              load_req
);
  localparam int CW1 = CNT_W + 1;

  phase_e             phase;
  logic [1:0]         mode;
  logic [CNT_W-1:0]   nlim;
  logic [CNT_W-1:0]   dcnt;
  logic [ADDR_W-1:0]  addr;
  logic [BYTE_W-1:0]  wdata;
  logic               wr_pend, adv_pend, ld_pend, ld_after;
  logic               cur_active, nxt_active;

  // byte i is live when no limit is set or i is below the limit
  assign cur_active = (nlim == '0) || (dcnt < nlim);
  assign nxt_active = (nlim == '0) ||
                      ((CW1'(dcnt) + CW1'(1)) < CW1'(nlim));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      mode     <= '0;
      nlim     <= '0;
      dcnt     <= '0;
      addr     <= '0;
      wdata    <= '0;
      wr_pend  <= 1'b0;
      adv_pend <= 1'b0;
      ld_pend  <= 1'b0;
      ld_after <= 1'b0;
    end else begin
      wr_pend  <= 1'b0;
      adv_pend <= 1'b0;
      ld_pend  <= 1'b0;
      if (adv_pend) begin
        addr    <= addr + 1'b1;
        ld_pend <= ld_after;
      end
      if (csb) begin
        phase <= PH_CMD;
        mode  <= '0;
        nlim  <= '0;
        dcnt  <= '0;
      end else if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            mode  <= byte_val[7:6];
            nlim  <= byte_val[5:3];
            phase <= (byte_val[7:6] == 2'b00) ? PH_SKIP : PH_ADDR;
          end
          PH_ADDR: begin
            addr    <= byte_val[ADDR_W-1:0];
            ld_pend <= mode[0];
            phase   <= PH_DATA;
          end
          PH_DATA: begin
            wdata    <= byte_val;
            wr_pend  <= mode[1] & cur_active;
            adv_pend <= 1'b1;
            ld_after <= mode[0] & nxt_active;
            if (dcnt != '1) dcnt <= dcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_we    = wr_pend;
  assign reg_addr  = addr;
  assign reg_wdata = wdata;
  assign load_req  = ld_pend & ~csb;
endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx
  import cfg_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb,
  input  logic              sck_fall,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output logic              miso
);
  logic [BYTE_W-1:0] txreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txreg <= '0;
      miso  <= 1'b0;
    end else if (csb) begin
      txreg <= '0;
      miso  <= 1'b0;
    end else if (load) begin
      txreg <= load_val;
    end else if (sck_fall) begin
      miso  <= txreg[BYTE_W-1];
      txreg <= {txreg[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
  import cfg_spi_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csb,
  input  logic              mosi,
  output logic              miso,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  logic              sck_fall;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [2:0]        bit_cnt;
  logic              load_req;

  cfg_spi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .mosi(mosi),
    .sck_fall(sck_fall), .byte_done(byte_done), .byte_val(byte_val),
    .bit_cnt(bit_cnt)
  );

  cfg_spi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csb(csb), .byte_done(byte_done),
    .byte_val(byte_val), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .load_req(load_req)
  );

  cfg_spi_tx u_tx (
    .clk(clk), .rst_n(rst_n), .csb(csb), .sck_fall(sck_fall),
    .load(load_req), .load_val(reg_rdata), .miso(miso)
  );
endmodule

// File: rtl/cfg_spi_slave_chk.sv
module cfg_spi_slave_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csb,
  input logic              miso,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              byte_done,
  input logic [2:0]        bit_cnt
);
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R10
  we_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(byte_done));

  // R3 R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we) |-> reg_addr == ADDR_W'($past(reg_addr) + 1'b1));

  // R7
  frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csb |=> bit_cnt == 3'd0);

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csb |=> !miso);
endmodule

bind cfg_spi_slave cfg_spi_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csb(csb), .miso(miso), .reg_we(reg_we),
  .reg_addr(reg_addr), .byte_done(byte_done), .bit_cnt(bit_cnt)
);

// File: tb/cfg_spi_slave_tb.sv
module cfg_spi_slave_tb;
  localparam int ADDR_W = 7;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csb = 1'b1, mosi = 1'b0;
  logic miso, reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] rf      [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  int vecs = 0, errs = 0, we_cnt = 0, cyc = 0;
  bit chk_idle = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_spi_slave #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .mosi(mosi),
    .miso(miso), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // environment register file
  assign reg_rdata = rf[reg_addr];
  always @(posedge clk) begin
    if (rst_n && reg_we) begin
      rf[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the register image while the link is idle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (chk_idle && !done) begin
      for (int k = 0; k < DEPTH; k++)
        if (rf[k] !== exp_mem[k]) begin
          errs++;
          $display("FAIL R9 reg 0x%0h actual=0x%0h expected=0x%0h", k, rf[k], exp_mem[k]);
        end
      vecs++;
      if (miso !== 1'b0 || reg_we !== 1'b0) begin
        errs++;
        $display("FAIL R1 idle miso/we actual=%b%b expected=00", miso, reg_we);
      end
    end
  end

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      wait_clk(HALF);
      rx[b] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic run_frame(input string tag, input logic [7:0] cmd,
                           input logic [7:0] a, input logic [7:0] d[$]);
    logic [7:0] old [DEPTH];
    logic [7:0] rx;
    logic [1:0] mode;
    int n, w0, commits;
    bit live;
    mode = cmd[7:6];
    n = int'(cmd[5:3]);
    for (int k = 0; k < DEPTH; k++) old[k] = exp_mem[k];
    chk_idle = 1'b0;
    w0 = we_cnt;
    commits = 0;
    csb = 1'b0;
    wait_clk(HALF);
    xfer_byte(cmd, rx);
    check({tag, " R6 cmd byte out"}, rx, 0);
    xfer_byte(a, rx);
    check({tag, " R6 addr byte out"}, rx, 0);
    foreach (d[i]) begin
      int ad;
      ad = (int'(a[ADDR_W-1:0]) + i) % DEPTH;
      live = (n == 0) || (i < n);
      xfer_byte(d[i], rx);
      if (mode == 2'b00)
        check({tag, " R2 noop out"}, rx, 0);
      else if (mode[0])
        check({tag, " R6 R11 read out"}, rx, live ? int'(old[ad]) : 0);
      else
        check({tag, " R2 write-only out"}, rx, 0);
      if (mode[1] && live) begin
        exp_mem[ad] = d[i];
        commits++;
      end
    end
    wait_clk(HALF);
    csb = 1'b1;
    wait_clk(4);
    check({tag, " R10 R4 write pulses"}, we_cnt - w0, commits);
    chk_idle = 1'b1;
    wait_clk(4);
  endtask

  initial begin
    logic [7:0] q[$];
    logic [7:0] rx;
    for (int k = 0; k < DEPTH; k++) begin
      rf[k] = 8'(k * 3 + 1);
      exp_mem[k] = 8'(k * 3 + 1);
    end
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(1);
    check("R1 reset miso", miso, 0);
    check("R1 reset we", reg_we, 0);
    chk_idle = 1'b1;
    wait_clk(4);

    q = '{8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h3C};
    run_frame("R5 R3 stream write", 8'h80, 8'h10, q);
    q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_frame("R5 R6 stream read", 8'h40, 8'h10, q);

    q = '{8'h1F, 8'h1F, 8'h1F, 8'h1F, 8'h1F, 8'h1F, 8'h1F, 8'h1F};
    run_frame("R9 fill 1F", 8'h80, 8'h30, q);
    q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_frame("R4 count 3 write", 8'h98, 8'h30, q);
    run_frame("R9 R4 readback", 8'h40, 8'h30, q);
    q = '{8'h00, 8'h00, 8'h00, 8'h00};
    run_frame("R6 count 2 read", 8'h50, 8'h30, q);

    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    run_frame("R11 rw stream", 8'hC0, 8'h31, q);
    q = '{8'h00, 8'h00, 8'h00, 8'h00};
    run_frame("R11 rw check", 8'h40, 8'h31, q);

    q = '{8'hE1, 8'hE2, 8'hE3, 8'hE4};
    run_frame("R8 wrap write", 8'h80, 8'hFE, q);
    run_frame("R8 wrap read", 8'h40, 8'h7E, q);

    q = '{8'h99, 8'h98, 8'h97};
    run_frame("R2 noop", 8'h00, 8'h20, q);

    // R7: abandon a frame mid-byte, then a fresh count-1 write
    chk_idle = 1'b0;
    csb = 1'b0;
    wait_clk(HALF);
    xfer_byte(8'h80, rx);
    xfer_byte(8'h05, rx);
    for (int b = 0; b < 5; b++) begin
      mosi = b[0];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    csb = 1'b1;
    wait_clk(4);
    check("R7 partial byte no write", rf[5], int'(exp_mem[5]));
    chk_idle = 1'b1;
    wait_clk(4);
    q = '{8'h6B, 8'h6C};
    run_frame("R7 R4 next frame count 1", 8'h88, 8'h05, q);

    q = '{8'h71, 8'h72, 8'h73, 8'h74, 8'h75, 8'h76, 8'h77, 8'h78, 8'h79};
    run_frame("R4 count 7 write", 8'hB8, 8'h40, q);
    run_frame("R6 count 7 read", 8'h78, 8'h40, q);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule